// File: doc/BRIEF.md
# Predictor-guided re-reference replacement for one cache set

This block keeps the replacement state of every way in a single cache set. Each way has a 2-bit re-reference value, a valid bit, the signature of the access that filled it, and a one-bit flag that records whether the line was used again after it was filled. The surrounding cache controller tells the block about hits and fills. The block names the way to replace next and produces the two events that train an external signature-indexed hit predictor.

A hit on a way makes that line near-immediate (value 0), sets its reuse flag and reports the line's stored signature as a train-up event. A fill goes into the way that `victim_way` shows in the same cycle. The new line starts at value 3 when the predictor reports a zero counter for its signature (`fill_distant` = 1), and at value 2 otherwise. If the evicted line was valid and was never reused, its signature is reported as a train-down event. The victim is chosen in this order: the lowest-numbered invalid way first. Among valid ways it is the lowest-numbered way holding 3. When no way holds 3, a fill first raises every way equally until one of them reaches 3.

Top module: `sigrrip_set`

## Requirements
- R1: After reset every way is invalid, `victim_way` is 0 and neither train output is asserted.
- R2: While any way is invalid, `victim_way` is the lowest-numbered invalid way. A fill into an invalid way produces no train-down event.
- R3: A fill writes the way shown on `victim_way` in that cycle. It stores `fill_sig` and clears the reuse flag. It sets the value to 3 when `fill_distant` is 1 and to 2 when it is 0.
- R4: When all ways are valid, `victim_way` is the lowest-numbered way with value 3. If no way holds 3, the fill first adds the same amount to every way, just enough that the largest value becomes 3. The replaced way is then the lowest-numbered way that was at the maximum.
- R5: A hit on a valid way sets its value to 0 and its reuse flag to 1. In the next cycle `train_up_vld` is high for one cycle with `train_up_sig` equal to the signature stored in that way.
- R6: A fill that replaces a valid way whose reuse flag is 0 raises `train_dn_vld` for one cycle in the next cycle, with `train_dn_sig` equal to that way's stored signature. If the flag is 1, no train-down event is produced.
- R7: A hit is ignored when `fill_vld` is high in the same cycle, and it is ignored when the hit way is invalid. An ignored hit changes no state and produces no train-up event.
- R8: The train outputs pulse only in the cycle after the hit or fill that caused them, and never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_vld | input | 1 | A hit occurred in this set |
| hit_way | input | WAY_W | Way that hit |
| fill_vld | input | 1 | Install a line into `victim_way` |
| fill_sig | input | SIG_W | Signature of the incoming line |
| fill_distant | input | 1 | Predictor counter for `fill_sig` is zero |
| victim_way | output | WAY_W | Way the next fill will replace |
| train_up_vld | output | 1 | Train-up event valid |
| train_up_sig | output | SIG_W | Signature to train up |
| train_dn_vld | output | 1 | Train-down event valid |
| train_dn_sig | output | SIG_W | Signature to train down |

## Verification
The bench first fills the empty set in order and confirms that no train-down event appears. A design that used the value search on invalid ways would pick the wrong way, and one that ignored the valid bit would emit stale signatures. It then forces aging, where no way holds 3, and checks that all ways rise together and the lowest-numbered maximum is replaced. A design that aged only once, or that aged unconditionally, would show a different victim on a later fill. It also evicts a line that was hit, to confirm the reuse flag suppresses training. It drives a hit and a fill in the same cycle, and a hit to an invalid way after reset; a wrong design would produce a spurious train-up event or corrupt a line's value.

// File: rtl/sigrrip_pkg.sv
// Shared constants and types for the predictor-guided set replacement block.
// Assumes the re-reference value is exactly two bits wide.
package sigrrip_pkg;
    localparam int RRPV_W = 2;
    localparam logic [RRPV_W-1:0] RRPV_DIST = '1;
    localparam logic [RRPV_W-1:0] RRPV_INTER = RRPV_DIST - 1'b1;
    localparam logic [RRPV_W-1:0] RRPV_NEAR = '0;
    typedef logic [RRPV_W-1:0] rrpv_t;
endpackage

// File: rtl/sigrrip_way.sv
// State of one way: valid bit, re-reference value, reuse flag and stored signature.
// Assumes the caller never asserts sel_fill and hit_sel together (the top gates hit).
module sigrrip_way
    import sigrrip_pkg::*;
#(
    parameter int SIG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_fill,
    input  logic             age_en,
    input  rrpv_t            age_delta,
    input  logic             hit_sel,
    input  rrpv_t            ins_val,
    input  logic [SIG_W-1:0] fill_sig,
    output logic             valid,
    output rrpv_t            rrpv,
    output logic             reused,
    output logic [SIG_W-1:0] sig
);
    // Update this way on fill, aging or hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            rrpv   <= RRPV_NEAR;
            reused <= 1'b0;
            sig    <= '0;
        end else if (sel_fill) begin
            valid  <= 1'b1;
            rrpv   <= ins_val;
            reused <= 1'b0;
            sig    <= fill_sig;
        end else if (age_en && valid) begin
            rrpv   <= rrpv + age_delta;
        end else if (hit_sel && valid) begin
            rrpv   <= RRPV_NEAR;
            reused <= 1'b1;
        end
    end
endmodule

// File: rtl/sigrrip_victim.sv
// Combinational victim search: lowest invalid way, else lowest way holding the maximum.
// Also gives the aging step that lifts the maximum value to distant.
module sigrrip_victim
    import sigrrip_pkg::*;
#(
    parameter int WAYS  = 16,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][RRPV_W-1:0] rrpv,
    output logic [WAY_W-1:0]            victim,
    output logic                        any_invalid,
    output rrpv_t                       age_delta
);
    logic [WAY_W-1:0] inv_idx;
    logic [WAY_W-1:0] max_idx;
    rrpv_t            max_val;

    // Find the lowest invalid way.
    always_comb begin
        inv_idx     = '0;
        any_invalid = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                inv_idx     = WAY_W'(i);
                any_invalid = 1'b1;
            end
        end
    end

    // Find the largest value and the lowest way that holds it.
    always_comb begin
        max_val = RRPV_NEAR;
        for (int i = 0; i < WAYS; i++) begin
            if (rrpv[i] > max_val) max_val = rrpv[i];
        end
        max_idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (rrpv[i] == max_val) max_idx = WAY_W'(i);
        end
    end

    // Select the victim and the aging step.
    always_comb begin
        victim    = any_invalid ? inv_idx : max_idx;
        age_delta = RRPV_DIST - max_val;
    end
endmodule

// File: rtl/sigrrip_train.sv
// Registers the train-up and train-down events so each pulses one cycle after its cause.
module sigrrip_train #(
    parameter int SIG_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_evt,
    input  logic [SIG_W-1:0] up_sig_in,
    input  logic             dn_evt,
    input  logic [SIG_W-1:0] dn_sig_in,
    output logic             up_vld,
    output logic [SIG_W-1:0] up_sig,
    output logic             dn_vld,
    output logic [SIG_W-1:0] dn_sig
);
    // Capture this cycle's training events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_vld <= 1'b0;
            up_sig <= '0;
            dn_vld <= 1'b0;
            dn_sig <= '0;
        end else begin
            up_vld <= up_evt;
            up_sig <= up_evt ? up_sig_in : '0;
            dn_vld <= dn_evt;
            dn_sig <= dn_evt ? dn_sig_in : '0;
        end
    end
endmodule

// File: rtl/sigrrip_set.sv
// Replacement state for one cache set under a 2-bit re-reference policy.
// The insertion value comes from an external signature predictor.
// Assumes WAYS is a power of two, so every hit_way code names a real way.
// Fill has priority over a hit in the same cycle.
module sigrrip_set
    import sigrrip_pkg::*;
#(
    parameter int WAYS  = 16,
    parameter int SIG_W = 14,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_vld,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             fill_vld,
    input  logic [SIG_W-1:0] fill_sig,
    input  logic             fill_distant,
    output logic [WAY_W-1:0] victim_way,
    output logic             train_up_vld,
    output logic [SIG_W-1:0] train_up_sig,
    output logic             train_dn_vld,
    output logic [SIG_W-1:0] train_dn_sig
);
    logic [WAYS-1:0]             way_valid;
    logic [WAYS-1:0]             way_reused;
    logic [WAYS-1:0][RRPV_W-1:0] way_rrpv;
    logic [WAYS-1:0][SIG_W-1:0]  way_sig;
    logic                        any_invalid;
    rrpv_t                       age_delta;
    rrpv_t                       ins_val;
    logic                        hit_take;
    logic                        evict_evt;
    logic                        age_en;

    sigrrip_victim #(.WAYS(WAYS)) victim_i (
        .valid       (way_valid),
        .rrpv        (way_rrpv),
        .victim      (victim_way),
        .any_invalid (any_invalid),
        .age_delta   (age_delta)
    );

    // Decode the request into per-way actions and training events.
    always_comb begin
        ins_val   = fill_distant ? RRPV_DIST : RRPV_INTER;
        hit_take  = hit_vld && !fill_vld && way_valid[hit_way];
        evict_evt = fill_vld && way_valid[victim_way] && !way_reused[victim_way];
        age_en    = fill_vld && !any_invalid;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        sigrrip_way #(.SIG_W(SIG_W)) way_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel_fill  (fill_vld && (victim_way == WAY_W'(w))),
            .age_en    (age_en),
            .age_delta (age_delta),
            .hit_sel   (hit_take && (hit_way == WAY_W'(w))),
            .ins_val   (ins_val),
            .fill_sig  (fill_sig),
            .valid     (way_valid[w]),
            .rrpv      (way_rrpv[w]),
            .reused    (way_reused[w]),
            .sig       (way_sig[w])
        );
    end

    sigrrip_train #(.SIG_W(SIG_W)) train_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_evt    (hit_take),
        .up_sig_in (way_sig[hit_way]),
        .dn_evt    (evict_evt),
        .dn_sig_in (way_sig[victim_way]),
        .up_vld    (train_up_vld),
        .up_sig    (train_up_sig),
        .dn_vld    (train_dn_vld),
        .dn_sig    (train_dn_sig)
    );
endmodule

// File: rtl/sigrrip_set_chk.sv
// Temporal checks on the training outputs of sigrrip_set, attached by bind.
module sigrrip_set_chk (
    input logic clk,
    input logic rst_n,
    input logic hit_vld,
    input logic fill_vld,
    input logic train_up_vld,
    input logic train_dn_vld
);
    // R5
    up_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_up_vld |-> $past(hit_vld));

    // R6
    dn_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_dn_vld |-> $past(fill_vld));

    // R7
    fill_masks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fill_vld) |-> !train_up_vld);

    // R8
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(train_up_vld && train_dn_vld));
endmodule

bind sigrrip_set sigrrip_set_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_vld      (hit_vld),
    .fill_vld     (fill_vld),
    .train_up_vld (train_up_vld),
    .train_dn_vld (train_dn_vld)
);

// File: tb/sigrrip_set_tb_top.sv
// Scoreboard bench: a driver task models the set and queues expected training events.
// A monitor pops and compares them as the design emits them.
module sigrrip_set_tb_top;
    localparam int WAYS  = 16;
    localparam int SIG_W = 14;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic             is_up;
        logic [SIG_W-1:0] sig;
    } evt_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             hit_vld = 1'b0;
    logic [WAY_W-1:0] hit_way = '0;
    logic             fill_vld = 1'b0;
    logic [SIG_W-1:0] fill_sig = '0;
    logic             fill_distant = 1'b0;
    logic [WAY_W-1:0] victim_way;
    logic             train_up_vld;
    logic [SIG_W-1:0] train_up_sig;
    logic             train_dn_vld;
    logic [SIG_W-1:0] train_dn_sig;

    int checks = 0;
    int errors = 0;
    evt_t exp_q[$];

    logic             m_val[WAYS];
    logic [1:0]       m_rr[WAYS];
    logic             m_use[WAYS];
    logic [SIG_W-1:0] m_sig[WAYS];

    always #5 clk = ~clk;

    sigrrip_set #(.WAYS(WAYS), .SIG_W(SIG_W)) dut_i (.*);

    task automatic model_clear();
        for (int i = 0; i < WAYS; i++) begin
            m_val[i] = 1'b0; m_rr[i] = 2'd0; m_use[i] = 1'b0; m_sig[i] = '0;
        end
    endtask

    function automatic int model_victim();
        int mx = 0;
        for (int i = 0; i < WAYS; i++) if (!m_val[i]) return i;
        for (int i = 0; i < WAYS; i++) if (int'(m_rr[i]) > mx) mx = int'(m_rr[i]);
        for (int i = 0; i < WAYS; i++) if (int'(m_rr[i]) == mx) return i;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle of request, update the model, queue expected events.
    task automatic do_op(input logic h, input int hw, input logic f,
                         input logic [SIG_W-1:0] fs, input logic fd);
        int v;
        int mx;
        v = model_victim();
        check("R2/R4 victim_way", int'(victim_way), v);
        hit_vld = h; hit_way = WAY_W'(hw); fill_vld = f; fill_sig = fs; fill_distant = fd;
        if (f) begin
            if (m_val[v] && !m_use[v]) exp_q.push_back('{is_up: 1'b0, sig: m_sig[v]});
            if (m_val[v]) begin
                mx = 0;
                for (int i = 0; i < WAYS; i++) if (int'(m_rr[i]) > mx) mx = int'(m_rr[i]);
                for (int i = 0; i < WAYS; i++) m_rr[i] = m_rr[i] + 2'(3 - mx);
            end
            m_val[v] = 1'b1; m_rr[v] = fd ? 2'd3 : 2'd2; m_use[v] = 1'b0; m_sig[v] = fs;
        end else if (h && m_val[hw]) begin
            exp_q.push_back('{is_up: 1'b1, sig: m_sig[hw]});
            m_rr[hw] = 2'd0; m_use[hw] = 1'b1;
        end
        @(negedge clk);
        hit_vld = 1'b0; fill_vld = 1'b0;
    endtask

    // Monitor: compare each emitted training event against the queue.
    always @(negedge clk) begin
        if (rst_n && (train_up_vld || train_dn_vld)) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R7/R8 unexpected event: actual up=%0b dn=%0b expected none",
                         train_up_vld, train_dn_vld);
            end else begin
                evt_t e;
                e = exp_q.pop_front();
                if (train_up_vld && train_dn_vld) begin
                    errors++;
                    $display("FAIL R8 both events: actual up=1 dn=1 expected one");
                end else if (e.is_up && !(train_up_vld && train_up_sig == e.sig)) begin
                    errors++;
                    $display("FAIL R5 train-up: actual vld=%0b sig=%0h expected sig=%0h",
                             train_up_vld, train_up_sig, e.sig);
                end else if (!e.is_up && !(train_dn_vld && train_dn_sig == e.sig)) begin
                    errors++;
                    $display("FAIL R6 train-down: actual vld=%0b sig=%0h expected sig=%0h",
                             train_dn_vld, train_dn_sig, e.sig);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        logic [15:0] lfsr;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 victim_way", int'(victim_way), 0);
        check("R1 train_up_vld", int'(train_up_vld), 0);
        check("R1 train_dn_vld", int'(train_dn_vld), 0);
        // R2/R3: fill empty set in order; ways 5 and 9 distant
        for (int i = 0; i < WAYS; i++)
            do_op(1'b0, 0, 1'b1, SIG_W'(14'h100 + i), (i == 5) || (i == 9));
        // R4: distant way 5 is the victim, evicting it trains down (R6)
        do_op(1'b0, 0, 1'b1, 14'h200, 1'b0);
        // R5: hit on way 9
        do_op(1'b1, 9, 1'b0, 14'h0, 1'b0);
        // R4: no way at 3 -> aging
        do_op(1'b0, 0, 1'b1, 14'h201, 1'b1);
        // R7: hit and fill together; hit ignored
        do_op(1'b1, 3, 1'b1, 14'h202, 1'b0);
        // R6: repeatedly fill until reused way 9 is replaced
        for (int i = 0; i < 20; i++) do_op(1'b0, 0, 1'b1, SIG_W'(14'h300 + i), 1'b0);
        // R5/R6/R4: pseudo-random mix
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] < 3'd3)
                do_op(1'b1, int'(lfsr[7:4]), 1'b0, 14'h0, 1'b0);
            else if (lfsr[2:0] == 3'd7)
                do_op(1'b1, int'(lfsr[7:4]), 1'b1, SIG_W'(lfsr[11:8]), lfsr[12]);
            else
                do_op(1'b0, 0, 1'b1, SIG_W'(lfsr[11:8]), lfsr[12] & lfsr[13]);
        end
        @(negedge clk);
        // R1/R7: reset mid-run, then hit an invalid way
        rst_n = 1'b0;
        model_clear();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 victim_way after reset", int'(victim_way), 0);
        do_op(1'b1, 5, 1'b0, 14'h0, 1'b0);
        do_op(1'b0, 0, 1'b1, 14'h3A, 1'b0);
        check("R2 victim_way next invalid", int'(victim_way), 1);
        repeat (2) @(negedge clk);
        check("R5/R6 queue drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule